// File: doc/BRIEF.md
# Two-Thread Core Idle State Resolver

This block keeps the idle state of each hardware thread in one core and derives the core's idle state from them. A thread in the running state (C0) can ask to go idle in two ways. A halt request takes it to C1 or C1E. A monitor-wait request takes it to C1, C1E, C3 or C6. The block records which of the two ways was used, because that choice decides which events can wake the thread.

Each thread has its own wake inputs. An interrupt aimed at a thread always wakes that thread. A write hit on the monitored address wakes the thread only if it went idle through monitor-wait. The core state is the shallowest of the thread states, which is the numerically lowest code. It is registered, so it follows the thread states one clock later. A wake on one thread therefore brings the core back to C0 even when the other thread stays idle.

Top module: `core_cstate_resolver`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every thread state and the core state read C0.
- R2: The state codes are C0=0, C1=1, C1E=2, C3=3 and C6=4.
  - A monitor-wait request from a thread in C0 with a code from 1 to 4 on its `mwait_code` field (bits 3i+2:3i) sets that thread's state to the code on the next clock.
  - A request with code 0, 5, 6 or 7 is ignored.
- R3: A halt request from a thread in C0 sets its state to C1 when `halt_deep` is 0, or to C1E when it is 1, on the next clock. A halt request never leads to any other state.
- R4: An interrupt on an idle thread returns that thread to C0 on the next clock. The other thread is not affected.
- R5: A monitor hit wakes an idle thread to C0 on the next clock only if that thread entered through monitor-wait. A thread that entered through halt stays in its state.
- R6: Idle requests that arrive while the thread is not in C0 are ignored.
- R7: If a thread in C0 sees an interrupt or a monitor hit in the same cycle as an idle request, it stays in C0.
- R8: If a halt request and a valid monitor-wait request arrive together, the monitor-wait request is taken. The entry is then treated as a monitor-wait entry for R5.
- R9: `core_state` equals the lowest of the thread states of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | NUM_THREADS | Per-thread halt idle request |
| halt_deep | input | NUM_THREADS | Per-thread halt depth select: 0 gives C1, 1 gives C1E |
| mwait_req | input | NUM_THREADS | Per-thread monitor-wait idle request |
| mwait_code | input | 3*NUM_THREADS | Per-thread requested state code, 3 bits per thread |
| irq | input | NUM_THREADS | Per-thread interrupt wake |
| mon_hit | input | NUM_THREADS | Per-thread monitored-address write hit |
| thread_state | output | 3*NUM_THREADS | Per-thread current state code, 3 bits per thread |
| core_state | output | 3 | Resolved core state code |

## Verification
A wrong entry-method flag stays hidden until a monitor hit arrives at an idle thread. It then shows up as a thread that wakes when it should not, or stays idle when it should wake, one clock after the hit. A wrong next-state decision shows on `thread_state` one clock after the request or wake. It reaches `core_state` one clock after that. The bench therefore mixes halt and monitor-wait entries with monitor hits, and compares both outputs against a reference model on every cycle.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
   localparam int CS_W = 3;
   typedef enum logic [CS_W-1:0] {
      CS_C0  = 3'd0,
      CS_C1  = 3'd1,
      CS_C1E = 3'd2,
      CS_C3  = 3'd3,
      CS_C6  = 3'd4
   } cstate_e;
   localparam logic [CS_W-1:0] CS_DEEPEST = 3'd4;
endpackage

// File: rtl/cstate_thread_track.sv
module cstate_thread_track
   import cstate_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_req,
   input  logic            halt_deep,
   input  logic            mwait_req,
   input  logic [CS_W-1:0] mwait_code,
   input  logic            irq,
   input  logic            mon_hit,
   output cstate_e         state,
   output logic            via_mwait
);
   cstate_e state_d;
   logic    via_d;
   logic    wake;
   logic    code_ok;
   logic    any_wake_in;

   assign wake        = irq | (mon_hit & via_mwait);
   assign any_wake_in = irq | mon_hit;
   assign code_ok     = (mwait_code != 3'd0) && (mwait_code <= CS_DEEPEST);

   always_comb begin
      state_d = state;
      via_d   = via_mwait;
      if (state != CS_C0) begin
         if (wake) begin
            state_d = CS_C0;
            via_d   = 1'b0;
         end
      end else if (!any_wake_in) begin
         if (mwait_req && code_ok) begin
            state_d = cstate_e'(mwait_code);
            via_d   = 1'b1;
         end else if (halt_req) begin
            state_d = halt_deep ? CS_C1E : CS_C1;
            via_d   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CS_C0;
         via_mwait <= 1'b0;
      end else begin
         state     <= state_d;
         via_mwait <= via_d;
      end
   end

   // R4
   irq_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && state != CS_C0) |=> (state == CS_C0));

   // R5
   halt_ignores_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_hit && !irq && !via_mwait && state != CS_C0) |=> $stable(state));

   // R6
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CS_C0 && !irq && !mon_hit) |=> $stable(state));

   // R7
   wake_beats_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CS_C0 && (irq || mon_hit)) |=> (state == CS_C0));

   // R3
   halt_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == CS_C0 && state != CS_C0 && !via_mwait)
         |-> (state == CS_C1 || state == CS_C1E));
endmodule

// File: rtl/cstate_min_resolve.sv
module cstate_min_resolve
   import cstate_pkg::*;
#(
   parameter int N_IN = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_IN*CS_W-1:0] in_states,
   output logic [CS_W-1:0]      core_q
);
   logic [CS_W-1:0] low;

   generate
      if (N_IN == 1) begin : g_single
         assign low = in_states[CS_W-1:0];
      end else begin : g_tree
         always_comb begin
            low = in_states[CS_W-1:0];
            for (int k = 1; k < N_IN; k++) begin
               if (in_states[k*CS_W +: CS_W] < low)
                  low = in_states[k*CS_W +: CS_W];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) core_q <= CS_C0;
      else        core_q <= low;
   end

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_chk
         // R9
         core_not_deeper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ##1 (core_q <= $past(in_states[i*CS_W +: CS_W])));
      end
   endgenerate
endmodule

// File: rtl/core_cstate_resolver.sv
module core_cstate_resolver
   import cstate_pkg::*;
#(
   parameter int NUM_THREADS = 2
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_THREADS-1:0]      halt_req,
   input  logic [NUM_THREADS-1:0]      halt_deep,
   input  logic [NUM_THREADS-1:0]      mwait_req,
   input  logic [NUM_THREADS*3-1:0]    mwait_code,
   input  logic [NUM_THREADS-1:0]      irq,
   input  logic [NUM_THREADS-1:0]      mon_hit,
   output logic [NUM_THREADS*3-1:0]    thread_state,
   output logic [2:0]                  core_state
);
   localparam int ST_W = NUM_THREADS * CS_W;

   generate
      if (NUM_THREADS < 1 || NUM_THREADS > 8) begin : g_bad_cfg
         $error("core_cstate_resolver: NUM_THREADS out of range");
      end
      if (CS_W != 3) begin : g_bad_w
         $error("core_cstate_resolver: state width must be 3");
      end
   endgenerate

   logic [ST_W-1:0]        st_flat;
   logic [NUM_THREADS-1:0] via_unused;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         cstate_e st;
         cstate_thread_track u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .halt_req   (halt_req[t]),
            .halt_deep  (halt_deep[t]),
            .mwait_req  (mwait_req[t]),
            .mwait_code (mwait_code[t*CS_W +: CS_W]),
            .irq        (irq[t]),
            .mon_hit    (mon_hit[t]),
            .state      (st),
            .via_mwait  (via_unused[t])
         );
         assign st_flat[t*CS_W +: CS_W] = st;
      end
   endgenerate

   cstate_min_resolve #(.N_IN(NUM_THREADS)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_states (st_flat),
      .core_q    (core_state)
   );

   assign thread_state = st_flat;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (thread_state == '0 && core_state == 3'd0));
endmodule

// File: tb/core_cstate_resolver_bench.sv
module core_cstate_resolver_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] halt_req = '0, halt_deep = '0, mwait_req = '0, irq = '0, mon_hit = '0;
   logic [5:0] mwait_code = '0;
   logic [5:0] thread_state;
   logic [2:0] core_state;

   int total = 0;
   int bad = 0;
   string tag = "R1";
   int exp_st[2];
   int exp_mw[2];
   int exp_core;

   always #2 clk = ~clk;

   core_cstate_resolver u_core_cstate_resolver (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_deep(halt_deep),
      .mwait_req(mwait_req), .mwait_code(mwait_code), .irq(irq),
      .mon_hit(mon_hit), .thread_state(thread_state), .core_state(core_state));

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic model_update();
      int nc;
      nc = (exp_st[0] < exp_st[1]) ? exp_st[0] : exp_st[1];
      if (!rst_n) begin
         exp_st[0] = 0; exp_st[1] = 0; exp_mw[0] = 0; exp_mw[1] = 0; exp_core = 0;
      end else begin
         exp_core = nc;
         for (int i = 0; i < 2; i++) begin
            int code;
            code = int'(mwait_code[i*3 +: 3]);
            if (exp_st[i] != 0) begin
               if (irq[i] || (mon_hit[i] && exp_mw[i] != 0)) begin
                  exp_st[i] = 0; exp_mw[i] = 0;
               end
            end else if (!irq[i] && !mon_hit[i]) begin
               if (mwait_req[i] && code >= 1 && code <= 4) begin
                  exp_st[i] = code; exp_mw[i] = 1;
               end else if (halt_req[i]) begin
                  exp_st[i] = halt_deep[i] ? 2 : 1; exp_mw[i] = 0;
               end
            end
         end
      end
   endtask

   task automatic compare();
      for (int i = 0; i < 2; i++) begin
         total++;
         if (int'(thread_state[i*3 +: 3]) != exp_st[i]) begin
            bad++;
            $display("FAIL %s thread%0d: actual=%0d expected=%0d", tag, i,
                     thread_state[i*3 +: 3], exp_st[i]);
         end
      end
      total++;
      if (int'(core_state) != exp_core) begin
         bad++;
         $display("FAIL R9 core (%s): actual=%0d expected=%0d", tag, core_state, exp_core);
      end
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_inputs();
      halt_req = '0; halt_deep = '0; mwait_req = '0; mwait_code = '0; irq = '0; mon_hit = '0;
   endtask

   task automatic wake_all();
      idle_inputs(); irq = 2'b11; step(); idle_inputs(); step();
   endtask

   initial begin
      exp_st[0] = 0; exp_st[1] = 0; exp_mw[0] = 0; exp_mw[1] = 0; exp_core = 0;
      @(negedge clk);
      tag = "R1";
      halt_req = 2'b11;
      step(); step();
      idle_inputs();
      rst_n = 1'b1;
      step(); step();

      // R2: monitor-wait entry to each valid code, invalid code ignored
      tag = "R2";
      for (int c = 0; c < 8; c++) begin
         mwait_req = 2'b01; mwait_code = {3'd0, 3'(c)}; step();
         idle_inputs(); step();
         wake_all();
      end

      // R3: halt to C1 and C1E
      tag = "R3";
      halt_req = 2'b11; halt_deep = 2'b10; step(); idle_inputs(); step(); step();
      wake_all();

      // R4 and R9: thread0 C1E, thread1 C3, then wake thread0 only
      tag = "R4";
      mwait_req = 2'b11; mwait_code = {3'd3, 3'd2}; step(); idle_inputs(); step(); step();
      irq = 2'b01; step(); idle_inputs(); step(); step();
      wake_all();

      // R5: monitor hit on halt entry vs monitor-wait entry
      tag = "R5";
      halt_req = 2'b01; mwait_req = 2'b10; mwait_code = {3'd4, 3'd0}; step();
      idle_inputs(); step();
      mon_hit = 2'b11; step(); idle_inputs(); step(); step();
      wake_all();

      // R6: requests while idle ignored
      tag = "R6";
      halt_req = 2'b11; step(); idle_inputs(); step();
      mwait_req = 2'b11; mwait_code = {3'd4, 3'd4}; halt_req = 2'b11; halt_deep = 2'b11;
      step(); step(); idle_inputs(); step();
      wake_all();

      // R7: wake and request together
      tag = "R7";
      halt_req = 2'b11; mwait_req = 2'b11; mwait_code = {3'd3, 3'd3};
      irq = 2'b01; mon_hit = 2'b10; step(); idle_inputs(); step();

      // R8: both requests together
      tag = "R8";
      halt_req = 2'b11; mwait_req = 2'b11; mwait_code = {3'd1, 3'd4}; step();
      idle_inputs(); step();
      mon_hit = 2'b11; step(); idle_inputs(); step();

      // mixed random traffic
      tag = "R9";
      for (int n = 0; n < 3000; n++) begin
         halt_req   = 2'($urandom);
         halt_deep  = 2'($urandom);
         mwait_req  = 2'($urandom);
         mwait_code = 6'($urandom);
         irq        = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
         mon_hit    = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
         step();
      end

      // R1: reset from idle
      tag = "R1";
      idle_inputs(); mwait_req = 2'b11; mwait_code = {3'd4, 3'd3}; step();
      idle_inputs(); rst_n = 1'b0; step(); rst_n = 1'b1; step();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule